// File: doc/BRIEF.md
# USB OUT Endpoint Handshake Controller

This block keeps the control and status state of two bulk OUT endpoints (endpoint numbers 1 and 2). For each received data packet it decides the handshake: ACK, STALL, or ignore. A serial interface engine reports each packet through a small event port: a one-cycle end-of-packet strobe, the endpoint number, whether the data PID was DATA1, and the byte count. The block answers one cycle later with a registered handshake code and a flag that says whether the payload should be kept.

Software reaches the state of one endpoint at a time. It writes an index register to pick the endpoint, then reads or writes a control/status word at a fixed word offset. That word holds three bits. A toggle-clear bit forces the next expected PID to DATA0. A stall-sent flag is set by hardware whenever a STALL goes out. A send-stall control makes the endpoint refuse every packet. The block also stalls any packet longer than the endpoint's maximum packet size. It tracks the expected data toggle per endpoint, so a repeated packet is acknowledged but its data is dropped.

Top module: `usb_out_ep_hs`

## Requirements
- R1: After a synchronous reset, the index register, every control/status bit and both expected toggles are 0, and `hs_valid` is low.
- R2: The index register (word offset 0x00E) selects the endpoint, 1 or 2, that the control/status word (word offset 0x050) reaches. With any other index, the word reads 0 and writes to it are ignored. Reads return data one cycle after the address is presented.
- R3: In the control/status word, bits 31:8 and 4:0 read as 0, and writing 1s to them has no effect.
- R4: A packet whose PID matches the expected toggle (DATA0 after reset), with no stall active and length within the maximum, gets ACK with `hs_accept`=1, and the expected toggle flips.
- R5: A packet whose PID does not match the expected toggle gets ACK with `hs_accept`=0, and the expected toggle stays unchanged.
- R6: A packet longer than the endpoint's maximum packet size (64 bytes by default) gets STALL and sets the stall-sent flag (bit 6). The toggle is unchanged. A packet of exactly 64 bytes is not stalled.
- R7: While send-stall (bit 5) is 1, every packet to that endpoint gets STALL and sets bit 6. Writing bit 5 as 0 ends the condition.
- R8: Writing 0 to bit 6 clears the stall-sent flag. Writing 1 leaves it as it was.
- R9: Writing 1 to bit 7 sets the next expected PID to DATA0. Bit 7 then reads 1 until the next packet to that endpoint clears it. Writing 0 to bit 7 has no effect.
- R10: A packet addressed to an endpoint number other than 1 or 2 gets the ignore code with `hs_accept`=0 and changes no endpoint state.
- R11: A register write to one endpoint and a packet on the other endpoint in the same cycle both take effect. If a STALL sets bit 6 in the same cycle that software writes it to 0, the flag ends up 1.
- R12: `hs_valid` pulses exactly one cycle after `pkt_end`. `hs_code` is 0 for ignore, 1 for ACK and 2 for STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 8 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the previous cycle's address |
| pkt_end | input | 1 | End-of-packet strobe, one cycle |
| pkt_ep | input | 4 | Endpoint number of the packet |
| pkt_data1 | input | 1 | 1 if the packet carried DATA1, 0 for DATA0 |
| pkt_len | input | 11 | Payload byte count |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 0 ignore, 1 ACK, 2 STALL |
| hs_accept | output | 1 | Payload should be kept |

## Verification
The expected toggle has no register bit of its own. A wrong toggle therefore shows only through `hs_accept` on the next packet to that endpoint, one cycle after its strobe. For that reason the bench always follows a toggle-affecting event with a packet whose PID exposes the toggle. Errors in the stall state or the toggle-clear flag show at the next register read, one cycle after the address is set, or as a wrong `hs_code` on the next packet. The bench pairs every such event with one of these observations before the next event.

// File: rtl/usb_out_hs_pkg.sv
package usb_out_hs_pkg;
  typedef enum logic [1:0] {
    HS_IGNORE = 2'd0,
    HS_ACK    = 2'd1,
    HS_STALL  = 2'd2
  } hs_code_e;

  // positions inside the 3-bit slice {tclr, stall_sent, send_stall}
  localparam int SL_TCLR  = 2;
  localparam int SL_SENT  = 1;
  localparam int SL_STALL = 0;
  // bit position of the slice's LSB in the 32-bit word
  localparam int CSR_LSB  = 5;
endpackage

// File: rtl/usb_out_ep_state.sv
module usb_out_ep_state
  import usb_out_hs_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter logic [LEN_W-1:0] MAXP = 11'd64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_bits,
  input  logic             pkt_hit,
  input  logic             pkt_data1,
  input  logic [LEN_W-1:0] pkt_len,
  output logic [2:0]       stat_bits,
  output logic [1:0]       dec_code,
  output logic             dec_accept
);
  logic tog, tclr, sent, sstall;
  logic oversize, stall_now, clr_req;

  assign oversize  = pkt_len > MAXP;
  assign stall_now = sstall | oversize;
  assign clr_req   = wr_en & wr_bits[SL_TCLR];

  always_comb begin
    if (stall_now) begin
      dec_code   = HS_STALL;
      dec_accept = 1'b0;
    end else begin
      dec_code   = HS_ACK;
      dec_accept = (pkt_data1 == tog);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog    <= 1'b0;
      tclr   <= 1'b0;
      sent   <= 1'b0;
      sstall <= 1'b0;
    end else begin
      if (clr_req)
        tog <= 1'b0;
      else if (pkt_hit && !stall_now && (pkt_data1 == tog))
        tog <= ~tog;

      if (clr_req)
        tclr <= 1'b1;
      else if (pkt_hit)
        tclr <= 1'b0;

      if (pkt_hit && stall_now)
        sent <= 1'b1;
      else if (wr_en && !wr_bits[SL_SENT])
        sent <= 1'b0;

      if (wr_en)
        sstall <= wr_bits[SL_STALL];
    end
  end

  assign stat_bits = {tclr, sent, sstall};

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_hit && dec_accept && !clr_req) |=> (tog != $past(tog)));
  // R5
  toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_hit && dec_code == HS_ACK && !dec_accept && !clr_req) |=> $stable(tog));
  // R6
  oversize_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_hit && pkt_len > MAXP && !clr_req) |=> (sent && $stable(tog)));
  // R8
  sent_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_bits[SL_SENT] && sent) |=> sent);
  // R9
  tclr_force_chk: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (!tog && tclr));
endmodule

// File: rtl/usb_out_csr_if.sv
module usb_out_csr_if
  import usb_out_hs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  parameter int NUM_EP = 2,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h50,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 8'h0E
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  input  logic [NUM_EP*3-1:0] ep_stat,
  output logic [NUM_EP-1:0]   ep_wr,
  output logic [2:0]          wr_bits,
  output logic [31:0]         cfg_rdata
);
  logic [IDX_W-1:0] idx;
  logic [2:0]       sel_stat;
  logic             unused_wdata;

  assign unused_wdata = ^cfg_wdata;
  assign wr_bits = cfg_wdata[CSR_LSB +: 3];

  always_ff @(posedge clk) begin
    if (rst)
      idx <= '0;
    else if (cfg_we && cfg_addr == IDX_ADDR)
      idx <= cfg_wdata[IDX_W-1:0];
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_wr
    assign ep_wr[g] = cfg_we && (cfg_addr == CSR_ADDR) && (idx == IDX_W'(g + 1));
  end

  always_comb begin
    sel_stat = 3'b000;
    for (int g = 0; g < NUM_EP; g++)
      if (idx == IDX_W'(g + 1)) sel_stat = ep_stat[g*3 +: 3];
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_rdata <= '0;
    else if (cfg_addr == IDX_ADDR)
      cfg_rdata <= {{(32-IDX_W){1'b0}}, idx};
    else if (cfg_addr == CSR_ADDR)
      cfg_rdata <= {{(32-CSR_LSB-3){1'b0}}, sel_stat, {CSR_LSB{1'b0}}};
    else
      cfg_rdata <= '0;
  end

  // R2
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (idx == '0 || idx > IDX_W'(NUM_EP)) |-> (ep_wr == '0));
endmodule

// File: rtl/usb_out_ep_hs.sv
module usb_out_ep_hs
  import usb_out_hs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  parameter int EP_W   = 4,
  parameter int LEN_W  = 11,
  parameter logic [LEN_W-1:0] MAXP_EP1 = 11'd64,
  parameter logic [LEN_W-1:0] MAXP_EP2 = 11'd64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              pkt_end,
  input  logic [EP_W-1:0]   pkt_ep,
  input  logic              pkt_data1,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic              hs_accept
);
  localparam int NUM_EP = 2;

  logic [NUM_EP*3-1:0] ep_stat;
  logic [NUM_EP-1:0]   ep_wr;
  logic [NUM_EP-1:0]   ep_hit;
  logic [2:0]          wr_bits;
  logic [1:0]          ep_dec [NUM_EP];
  logic [NUM_EP-1:0]   ep_acc;
  logic [1:0]          pick_code;
  logic                pick_acc;

  usb_out_csr_if #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_EP(NUM_EP)
  ) csr_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ep_stat(ep_stat), .ep_wr(ep_wr),
    .wr_bits(wr_bits), .cfg_rdata(cfg_rdata)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    localparam logic [LEN_W-1:0] MAXP = (g == 0) ? MAXP_EP1 : MAXP_EP2;
    assign ep_hit[g] = pkt_end && (pkt_ep == EP_W'(g + 1));
    usb_out_ep_state #(.LEN_W(LEN_W), .MAXP(MAXP)) st_i (
      .clk(clk), .rst(rst), .wr_en(ep_wr[g]), .wr_bits(wr_bits),
      .pkt_hit(ep_hit[g]), .pkt_data1(pkt_data1), .pkt_len(pkt_len),
      .stat_bits(ep_stat[g*3 +: 3]), .dec_code(ep_dec[g]),
      .dec_accept(ep_acc[g])
    );
  end

  always_comb begin
    pick_code = HS_IGNORE;
    pick_acc  = 1'b0;
    for (int g = 0; g < NUM_EP; g++)
      if (ep_hit[g]) begin
        pick_code = ep_dec[g];
        pick_acc  = ep_acc[g];
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid  <= 1'b0;
      hs_code   <= HS_IGNORE;
      hs_accept <= 1'b0;
    end else begin
      hs_valid  <= pkt_end;
      hs_code   <= pick_code;
      hs_accept <= pick_acc;
    end
  end

  // R12
  hs_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> hs_valid);
  // R12
  hs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pkt_end |=> !hs_valid);
  // R10
  foreign_ep_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_end && (pkt_ep == '0 || pkt_ep > EP_W'(NUM_EP)))
      |=> (hs_code == HS_IGNORE && !hs_accept));
  // R12
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> (hs_code != 2'd3));
endmodule

// File: tb/usb_out_ep_hs_tb_top.sv
module usb_out_ep_hs_tb_top;
  localparam logic [7:0] A_CSR = 8'h50;
  localparam logic [7:0] A_IDX = 8'h0E;
  localparam int MAXP = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pkt_end = 1'b0;
  logic [3:0]  pkt_ep = '0;
  logic        pkt_data1 = 1'b0;
  logic [10:0] pkt_len = '0;
  logic        hs_valid;
  logic [1:0]  hs_code;
  logic        hs_accept;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [1:0] code;
    logic       acc;
    string      req;
  } item_t;
  item_t sb[$];

  // model of the requirements
  bit m_tog [4];
  bit m_ss  [4];
  bit m_sent[4];
  bit m_tclr[4];
  int m_idx = 0;

  always #5 clk = ~clk;

  usb_out_ep_hs dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pkt_end(pkt_end),
    .pkt_ep(pkt_ep), .pkt_data1(pkt_data1), .pkt_len(pkt_len),
    .hs_valid(hs_valid), .hs_code(hs_code), .hs_accept(hs_accept)
  );

  function automatic bit valid_ep(int e);
    return (e == 1 || e == 2);
  endfunction

  function automatic logic [31:0] exp_csr();
    if (!valid_ep(m_idx)) return 32'h0;
    return {24'h0, m_tclr[m_idx], m_sent[m_idx], m_ss[m_idx], 5'h0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // model a packet; returns whether a stall set bit 6
  function automatic bit model_pkt(int e, bit d1, int len, string req);
    item_t it;
    bit hw = 1'b0;
    it.req = req;
    if (!valid_ep(e)) begin
      it.code = 2'd0; it.acc = 1'b0;
    end else begin
      if (m_ss[e] || len > MAXP) begin
        it.code = 2'd2; it.acc = 1'b0; m_sent[e] = 1'b1; hw = 1'b1;
      end else if (d1 == m_tog[e]) begin
        it.code = 2'd1; it.acc = 1'b1; m_tog[e] = ~m_tog[e];
      end else begin
        it.code = 2'd1; it.acc = 1'b0;
      end
      m_tclr[e] = 1'b0;
    end
    sb.push_back(it);
    return hw;
  endfunction

  function automatic void model_wr(logic [7:0] a, logic [31:0] d, bit hw);
    if (a == A_IDX) m_idx = int'(d[3:0]);
    else if (a == A_CSR && valid_ep(m_idx)) begin
      if (d[7]) begin m_tog[m_idx] = 1'b0; m_tclr[m_idx] = 1'b1; end
      if (!d[6] && !hw) m_sent[m_idx] = 1'b0;
      m_ss[m_idx] = d[5];
    end
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    model_wr(a, d, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    cfg_addr = a;
    @(negedge clk);
    check(cfg_rdata === exp, req, cfg_rdata, exp);
  endtask

  task automatic rd_csr(input string req);
    rd(A_CSR, exp_csr(), req);
  endtask

  task automatic pkt(input int e, input bit d1, input int len, input string req);
    bit hw;
    pkt_end = 1'b1; pkt_ep = 4'(e); pkt_data1 = d1; pkt_len = 11'(len);
    hw = model_pkt(e, d1, len, req);
    @(negedge clk);
    check(hs_valid === 1'b1, "R12 timing", {31'h0, hs_valid}, 32'h1);
    pkt_end = 1'b0;
  endtask

  // R11: write to the selected endpoint and packet in the same cycle
  task automatic wr_pkt(input logic [31:0] d, input int e, input bit d1,
                        input int len, input string req);
    bit hw;
    cfg_we = 1'b1; cfg_addr = A_CSR; cfg_wdata = d;
    pkt_end = 1'b1; pkt_ep = 4'(e); pkt_data1 = d1; pkt_len = 11'(len);
    hw = model_pkt(e, d1, len, req);
    model_wr(A_CSR, d, hw && (e == m_idx));
    @(negedge clk);
    cfg_we = 1'b0; pkt_end = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done && hs_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R12 unexpected handshake", {30'h0, hs_code}, 32'h0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(hs_code === it.code, it.req, {30'h0, hs_code}, {30'h0, it.code});
        check(hs_accept === it.acc, it.req, {31'h0, hs_accept}, {31'h0, it.acc});
      end
    end
  end

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(hs_valid === 1'b0, "R1 hs_valid", {31'h0, hs_valid}, 32'h0);
    rd(A_IDX, 32'h0, "R1 index");
    rd_csr("R1 csr");
    // R2 selection
    wr(A_IDX, 32'h1);
    rd(A_IDX, 32'h1, "R2 index readback");
    rd_csr("R2 ep1 csr");
    // R4 / R5 / R6 on ep1
    pkt(1, 1'b0, 8,  "R4 DATA0 first");
    pkt(1, 1'b1, 64, "R6 exact max accepted");
    pkt(1, 1'b1, 10, "R5 repeat DATA1");
    pkt(1, 1'b0, 12, "R4 DATA0 again");
    pkt(1, 1'b1, 65, "R6 oversize");
    rd_csr("R6 stall-sent set");
    pkt(1, 1'b1, 8,  "R6 toggle kept");
    // R8
    wr(A_CSR, 32'h40);
    rd_csr("R8 write 1 keeps");
    wr(A_CSR, 32'h00);
    rd_csr("R8 write 0 clears");
    // R7
    wr(A_CSR, 32'h20);
    rd_csr("R7 send-stall set");
    pkt(1, 1'b0, 4, "R7 stalled 1");
    pkt(1, 1'b1, 4, "R7 stalled 2");
    rd_csr("R7 stall-sent after stall");
    wr(A_CSR, 32'h00);
    rd_csr("R7 cleared");
    pkt(1, 1'b0, 4, "R7 ack after end");
    // R9
    wr(A_CSR, 32'h80);
    rd_csr("R9 tclr reads 1");
    pkt(1, 1'b0, 4, "R9 DATA0 expected");
    rd_csr("R9 tclr auto-cleared");
    wr(A_CSR, 32'h00);
    pkt(1, 1'b1, 4, "R9 write 0 no effect");
    // R3
    wr(A_CSR, 32'hFFFF_FF1F);
    rd_csr("R3 reserved bits");
    // R2 other endpoints
    wr(A_IDX, 32'h2);
    rd_csr("R2 ep2 separate");
    wr(A_CSR, 32'h20);
    rd_csr("R2 ep2 written");
    wr(A_IDX, 32'h1);
    rd_csr("R2 ep1 untouched");
    wr(A_IDX, 32'h3);
    wr(A_CSR, 32'hA0);
    rd_csr("R2 bad index reads 0");
    wr(A_IDX, 32'h2);
    rd_csr("R2 bad index write ignored");
    pkt(2, 1'b0, 4, "R7 ep2 stalled");
    wr(A_CSR, 32'h00);
    // R10
    pkt(0, 1'b0, 4, "R10 ep0 ignored");
    pkt(3, 1'b1, 4, "R10 ep3 ignored");
    rd_csr("R10 ep2 state unchanged");
    pkt(2, 1'b0, 4, "R10 ep2 toggle intact");
    // R11
    wr(A_IDX, 32'h1);
    wr_pkt(32'h20, 2, 1'b1, 4, "R11 ep2 packet with ep1 write");
    rd_csr("R11 ep1 write landed");
    wr(A_CSR, 32'h00);
    wr(A_IDX, 32'h2);
    wr_pkt(32'h00, 2, 1'b0, 100, "R11 stall vs clear");
    rd_csr("R11 hw set wins");
    pkt(2, 1'b0, 4, "R11 ep2 toggle after stall");
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R12 all handshakes seen", 32'(sb.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule